// File: doc/BRIEF.md
# MDIO Management Master Controller

This block runs Clause 22 management transactions toward external Ethernet PHYs on a two-wire serial interface, a management clock and a bidirectional data line. Software sees three word registers on a simple register bus. A single write to the command register supplies the opcode, the 5-bit PHY and register addresses and, for a write, the 16-bit payload. The controller then serialises the whole frame. A busy flag in the status register shows that a frame is in progress. When a read has finished, the data register holds the 16 captured bits and a 2-bit failure code.

The management clock is the system clock divided by `2*MDC_HALF`. The data line is updated just after each falling edge of the management clock and is sampled on each rising edge. During a read the controller releases the line from the turnaround through the end of the data phase. If no PHY answers, a pull-up keeps the line high during the second turnaround bit, and the read is reported as failed. Software can use this to find empty PHY addresses.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Status register (offset 0x0) bit 3 reads 1 from the cycle after an accepted command until the frame has ended; all other status bits read 0. The bus returns read data one cycle after `busRdEn`.
- R2: A write to offset 0x8 with bit 31 set starts a transaction. The command word has PHY address in bits 29:25, register address in bits 24:20, write data in bits 19:4, bit 1 = write opcode and bit 2 = read opcode.
- R3: A write frame is 64 bits, sent MSB first with the data line driven throughout: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, 16 data bits.
- R4: A read frame sends 32 ones, start 01, opcode 10, PHY address and register address. From bit 46 (first turnaround bit) through bit 63 the output enable is low.
- R5: Data register (offset 0xC) bits 15:0 hold the 16 bits sampled in the data phase of the last completed read, MSB first. It changes only when a read frame ends.
- R6: Data register bits 17:16 are both 1 when the line is high at the second turnaround bit of a read, and both 0 otherwise. Bits 31:18 read 0.
- R7: A command written while busy is 1 is ignored: it starts no frame and leaves the current one unchanged.
- R8: A command with bit 31 clear, with both opcode bits set, or with neither opcode bit set is a no-operation: busy stays 0 and no frame is sent.
- R9: The management clock has a period of `2*MDC_HALF` system clocks, and the data output changes only in the cycle where the management clock falls.
- R10: After reset the status and data registers read 0 and the output enable is low; a write frame leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdEn | input | 1 | Register read strobe |
| busRdData | output | 32 | Register read data, valid one cycle after busRdEn |
| mdcOut | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | Serial data out |
| mdioOe | output | 1 | Output enable for the data line pad |
| mdioIn | input | 1 | Serial data in from the pad |

## Verification
A bit counter or state that has drifted shows up as a garbled header or a misplaced turnaround within the first frame. The bench's PHY model catches this at the first mismatching bit, and an output enable that stays high past bit 46 is flagged in the same frame. If the sample position for the turnaround or the data phase is wrong, the captured value read from the data register at the end of that read is wrong, and the flags from a missing PHY are wrong too. If acceptance control is broken, an unexpected frame appears on the line or busy asserts after a no-op. Both are seen within a few hundred cycles, before the next command.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_LEN = 64;
  localparam int REL_IDX   = 46;  // first turnaround bit
  localparam int TA2_IDX   = 47;  // second turnaround bit
  localparam int DATA_IDX  = 48;  // first data bit
  localparam int CNT_W     = $clog2(FRAME_LEN);

  localparam logic [3:0] OFS_STATUS = 4'h0;
  localparam logic [3:0] OFS_CMD    = 4'h8;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam int BUSY_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_SHIFT
  } ctlState_t;

  typedef struct packed {
    logic load;        // take a new command
    logic loadRead;    // new command is a read
    logic advance;     // present next frame bit
    logic driveNext;   // output enable for that bit
    logic finish;      // frame over, release line
    logic commitRd;    // copy read result to data register
    logic sampleTa;    // sample second turnaround bit
    logic sampleData;  // shift in a data bit
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
module mdio_mgmt_clkdiv #(
  parameter int MDC_HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic mdc,
  output logic fallTick,
  output logic riseTick
);
  localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

  logic [DIV_W-1:0] divCnt;
  logic             terminal;

  assign terminal = (divCnt == DIV_W'(MDC_HALF - 1));
  assign fallTick = terminal && mdc;
  assign riseTick = terminal && !mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (terminal) begin
      divCnt <= '0;
      mdc    <= !mdc;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  a_r9_tick_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(fallTick && riseTick));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic        cmdValid,
  input  logic        cmdRd,
  input  logic        cmdWr,
  input  logic        fallTick,
  input  logic        riseTick,
  output mdioStrobe_t strb,
  output logic        busy
);
  ctlState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             isRead;
  logic             lastBit;

  assign nextCnt = bitCnt + 1'b1;
  assign lastBit = (bitCnt == CNT_W'(FRAME_LEN - 1));
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strb          = '0;
    strb.load     = cmdWrite && cmdValid && (cmdRd ^ cmdWr) && (state == ST_IDLE);
    strb.loadRead = cmdRd;
    case (state)
      ST_ARM: begin
        if (fallTick) begin
          strb.advance   = 1'b1;
          strb.driveNext = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (fallTick) begin
          if (lastBit) begin
            strb.finish   = 1'b1;
            strb.commitRd = isRead;
          end else begin
            strb.advance   = 1'b1;
            strb.driveNext = !(isRead && (nextCnt >= CNT_W'(REL_IDX)));
          end
        end
        if (riseTick && isRead) begin
          strb.sampleTa   = (bitCnt == CNT_W'(TA2_IDX));
          strb.sampleData = (bitCnt >= CNT_W'(DATA_IDX));
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (strb.load) begin
            state  <= ST_ARM;
            isRead <= cmdRd;
          end
        end
        ST_ARM: begin
          if (fallTick) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (fallTick) begin
            if (lastBit) state <= ST_IDLE;
            else         bitCnt <= nextCnt;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: once busy, stays busy until the frame ends
  a_r1_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> busy);

  // R5: a read result is committed only by a read frame
  a_r5_commit_only_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitRd |-> isRead);

endmodule

// File: rtl/mdio_mgmt_datapath.sv
module mdio_mgmt_datapath
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strb,
  input  logic        busyIn,
  input  logic [31:0] cmdWord,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [31:0] dataReg
);
  logic [FRAME_LEN-1:0] shReg;
  logic [FRAME_LEN-1:0] newFrame;
  logic [15:0]          rdShift;
  logic                 taErr;
  logic                 unusedBits;

  assign unusedBits = ^{cmdWord[31:30], cmdWord[3:0]};

  always_comb begin
    newFrame = {32'hFFFF_FFFF, 2'b01,
                strb.loadRead ? 2'b10 : 2'b01,
                cmdWord[29:25], cmdWord[24:20],
                strb.loadRead ? 2'b11 : 2'b10,
                strb.loadRead ? 16'hFFFF : cmdWord[19:4]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
      rdShift <= '0;
      taErr   <= 1'b0;
      dataReg <= '0;
    end else begin
      if (strb.load) begin
        shReg <= newFrame;
        taErr <= 1'b0;
      end else if (strb.advance) begin
        mdioOut <= shReg[FRAME_LEN-1];
        shReg   <= {shReg[FRAME_LEN-2:0], 1'b0};
        mdioOe  <= strb.driveNext;
      end else if (strb.finish) begin
        mdioOe <= 1'b0;
      end
      if (strb.sampleTa)   taErr   <= mdioIn;
      if (strb.sampleData) rdShift <= {rdShift[14:0], mdioIn};
      if (strb.commitRd)   dataReg <= {14'b0, taErr, taErr, rdShift};
    end
  end

  // R7: a new frame is never loaded over a running one
  a_r7_load_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !busyIn);

  // R5: data register holds between read completions
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitRd |=> $stable(dataReg));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 2,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic              mdcOut,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrobe_t strb;
  logic        busy;
  logic        fallTick;
  logic        riseTick;
  logic        cmdWrite;
  logic [31:0] dataReg;

  assign cmdWrite = busWrEn && (busAddr == ADDR_W'(OFS_CMD));

  mdio_mgmt_clkdiv #(.MDC_HALF(MDC_HALF)) u_clkdiv (
    .clk      (clk),
    .rstN     (rstN),
    .mdc      (mdcOut),
    .fallTick (fallTick),
    .riseTick (riseTick)
  );

  mdio_mgmt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (cmdWrite),
    .cmdValid (busWrData[31]),
    .cmdRd    (busWrData[2]),
    .cmdWr    (busWrData[1]),
    .fallTick (fallTick),
    .riseTick (riseTick),
    .strb     (strb),
    .busy     (busy)
  );

  mdio_mgmt_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busyIn  (busy),
    .cmdWord (busWrData),
    .mdioIn  (mdioIn),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe),
    .dataReg (dataReg)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (busRdEn) begin
      case (busAddr)
        ADDR_W'(OFS_STATUS): busRdData <= 32'(busy) << BUSY_BIT;
        ADDR_W'(OFS_DATA):   busRdData <= dataReg;
        default:             busRdData <= '0;
      endcase
    end
  end

  // R9: data output moves only with a falling management clock
  a_r9_mdio_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> $fell(mdcOut));

  // R1: the line is driven only while busy
  a_r1_oe_within_busy: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);

  // R8: busy rises only after a valid command write
  a_r8_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdWrite && busWrData[31]));

endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;
  localparam int MDC_HALF   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        mdcOut, mdioOut, mdioOe, mdioIn;
  logic        phyDrv = 1'b0;
  logic        phyVal = 1'b1;

  // pull-up when nobody drives the line
  assign mdioIn = phyDrv ? phyVal : (mdioOe ? mdioOut : 1'b1);

  mdio_mgmt_master #(.MDC_HALF(MDC_HALF), .ADDR_W(4)) i_mdio_mgmt_master (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .mdcOut(mdcOut), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  always #(CLK_PERIOD/2) clk = !clk;

  typedef struct {
    logic [63:0] frame;
    bit          isRd;
    bit          present;
    logic [15:0] phyData;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int fails = 0;
  int frameCount = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(bit v, bit rd, bit wr, logic [4:0] phy,
                                        logic [4:0] rg, logic [15:0] d);
    return {v, 1'b0, phy, rg, d, 1'b0, rd, wr, 1'b0};
  endfunction

  function automatic logic [63:0] mkFrame(bit rd, logic [4:0] phy,
                                          logic [4:0] rg, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : d};
  endfunction

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int n = 0; n < 2000; n++) begin
      busRead(4'h0, s);
      if (!s[3]) return;
    end
    chk(1'b0, "R1 busy never cleared", 64'(s), 64'h0);
  endtask

  // driver: pushes the expected frame, issues the command, checks registers
  task automatic doCmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input bit present,
                       input logic [31:0] expData);
    item_t it;
    logic [31:0] s;
    it.frame = mkFrame(rd, phy, rg, d);
    it.isRd = rd; it.present = present; it.phyData = d;
    expQ.push_back(it);
    busWrite(4'h8, mkCmd(1'b1, rd, !rd, phy, rg, d));
    busRead(4'h0, s);
    chk(s == 32'h8, "R1 busy after command", 64'(s), 64'h8);
    waitIdle();
    busRead(4'hC, s);
    chk(s == expData, rd ? "R5/R6 data register after read" :
        "R10 data register kept by write", 64'(s), 64'(expData));
  endtask

  // monitor: PHY model and frame scoreboard
  initial begin
    forever begin
      item_t it;
      logic [63:0] got;
      bit rd, pres, oeBad;
      @(posedge mdioOe);
      frameCount++;
      got = '0; oeBad = 1'b0;
      if (expQ.size() == 0) begin
        chk(1'b0, "R7/R8 unexpected frame", 64'(frameCount), 64'h0);
        it.frame = '0; it.isRd = 1'b0; it.present = 1'b0; it.phyData = '0;
      end else begin
        it = expQ.pop_front();
      end
      rd = it.isRd; pres = it.present;
      for (int i = 0; i < 64; i++) begin
        @(posedge mdcOut);
        got[63-i] = mdioOut;
        if (rd && i >= 46 && mdioOe) oeBad = 1'b1;
        if (!rd && !mdioOe) oeBad = 1'b1;
        if (rd && i >= 45 && i < 63) begin
          @(negedge mdcOut);
          if (i + 1 == 46) begin
            phyDrv = 1'b0;
          end else if (i + 1 == 47) begin
            phyDrv = pres; phyVal = 1'b0;
          end else begin
            phyDrv = pres; phyVal = it.phyData[63-(i+1)];
          end
        end
      end
      @(negedge mdcOut);
      phyDrv = 1'b0;
      if (rd) begin
        chk(got[63:18] == it.frame[63:18], "R4 read header", 64'(got[63:18]),
            64'(it.frame[63:18]));
        chk(!oeBad, "R4 line released from turnaround", 64'(oeBad), 64'h0);
      end else begin
        chk(got == it.frame, "R3 write frame", got, it.frame);
        chk(!oeBad, "R3 line driven whole write frame", 64'(oeBad), 64'h0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    realtime t0, t1;
    int framesBefore;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    busRead(4'h0, s);
    chk(s == 32'h0, "R10 status after reset", 64'(s), 64'h0);
    busRead(4'hC, s);
    chk(s == 32'h0, "R10 data after reset", 64'(s), 64'h0);
    chk(mdioOe == 1'b0, "R10 output enable after reset", 64'(mdioOe), 64'h0);

    // R9 management clock period
    @(posedge mdcOut); t0 = $realtime;
    @(posedge mdcOut); t1 = $realtime;
    chk(int'((t1 - t0) / CLK_PERIOD) == 2 * MDC_HALF, "R9 mdc period",
        64'(int'((t1 - t0) / CLK_PERIOD)), 64'(2 * MDC_HALF));

    // R2 R3 writes with different field patterns
    doCmd(1'b0, 5'h05, 5'h03, 16'hA5C3, 1'b1, 32'h0);
    doCmd(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b1, 32'h0);
    doCmd(1'b0, 5'h00, 5'h00, 16'h0000, 1'b1, 32'h0);

    // R4 R5 read from a present PHY
    doCmd(1'b1, 5'h01, 5'h02, 16'h1234, 1'b1, 32'h0000_1234);
    // R6 read from an empty address: pulled-up line
    doCmd(1'b1, 5'h1E, 5'h02, 16'h0000, 1'b0, 32'h0003_FFFF);
    // R6 flags clear on a good read
    doCmd(1'b1, 5'h0A, 5'h11, 16'hBEEF, 1'b1, 32'h0000_BEEF);
    // R10 write does not disturb the data register
    doCmd(1'b0, 5'h0A, 5'h11, 16'h5555, 1'b1, 32'h0000_BEEF);

    // R7 command while busy
    begin
      item_t it;
      it.frame = mkFrame(1'b0, 5'h12, 5'h04, 16'hC0DE);
      it.isRd = 1'b0; it.present = 1'b1; it.phyData = 16'hC0DE;
      expQ.push_back(it);
      framesBefore = frameCount;
      busWrite(4'h8, mkCmd(1'b1, 1'b0, 1'b1, 5'h12, 5'h04, 16'hC0DE));
      busWrite(4'h8, mkCmd(1'b1, 1'b1, 1'b0, 5'h07, 5'h07, 16'h0000));
      waitIdle();
      repeat (400) @(negedge clk);
      chk(frameCount == framesBefore + 1, "R7 second command ignored",
          64'(frameCount - framesBefore), 64'h1);
      busRead(4'hC, s);
      chk(s == 32'h0000_BEEF, "R7 ignored read left data register",
          64'(s), 64'h0000_BEEF);
    end

    // R8 no-operation encodings
    framesBefore = frameCount;
    busWrite(4'h8, mkCmd(1'b0, 1'b0, 1'b1, 5'h03, 5'h03, 16'h1111));
    busRead(4'h0, s);
    chk(s == 32'h0, "R8 valid clear is no-op", 64'(s), 64'h0);
    busWrite(4'h8, mkCmd(1'b1, 1'b1, 1'b1, 5'h03, 5'h03, 16'h2222));
    busRead(4'h0, s);
    chk(s == 32'h0, "R8 both opcodes is no-op", 64'(s), 64'h0);
    busWrite(4'h8, mkCmd(1'b1, 1'b0, 1'b0, 5'h03, 5'h03, 16'h3333));
    busRead(4'h0, s);
    chk(s == 32'h0, "R8 no opcode is no-op", 64'(s), 64'h0);
    repeat (400) @(negedge clk);
    chk(frameCount == framesBefore, "R8 no frame sent",
        64'(frameCount - framesBefore), 64'h0);

    chk(expQ.size() == 0, "R3 all expected frames seen", 64'(expQ.size()), 64'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule